// File: doc/BRIEF.md
# Multichannel Serial Audio Input Port

This block receives up to eight independent serial audio streams. Each stream has its own bit clock, frame-select line and data line, all asynchronous to the system clock. The block oversamples every line with the system clock, recovers the bits on the rising edges of each bit clock and frames them as I2S, left-justified or right-justified. Every received sample becomes one 32-bit word. All channels share one small output queue.

A frame is 64 bit clocks long. It is made of two 32-bit halves, and each half carries one sample. So one frame-select period yields a left sample and a right sample, and these two samples enter the queue as two separate words. Each channel first parks its finished words in a two-entry local buffer. A round-robin arbiter then moves at most one word per system clock into the shared eight-entry queue. The queue is drained through a valid/ready port. Each word carries the number of its channel and a right-side flag. When the queue is full and a channel's local buffer is also full, the newest word of that channel is discarded and a sticky flag for that channel is raised.

Top module: `audio_in_mux`

## Requirements
- R1: After reset `out_valid` is 0 and every bit of `ovf_flag` is 0.
- R2: Left-justified framing (format code 1): the MSB arrives on the first bit-clock rising edge after the frame-select line changes. A high frame-select marks the left half. Word widths of 24 and 32 are received correctly.
- R3: I2S framing (format code 0): the MSB arrives one bit clock after the frame-select change. A low frame-select marks the left half. Word widths of 24 and 32 are received correctly.
- R4: Right-justified framing (format code 2): the LSB is the last bit before the frame-select change. A high frame-select marks the left half. Word widths of 16, 18, 20 and 24 are received correctly.
- R5: The width code selects the sample width: 0 selects 16 bits, 1 selects 18, 2 selects 20, 3 selects 24, and 4 to 7 select 32. A sample is output MSB-aligned at bit 31, with zeros below it. Bits of the 32-bit half that lie outside the sample do not change the output.
- R6: Each output word carries its channel index on `out_ch`. It also carries `out_right`, which is 0 for the left sample and 1 for the right sample. Within a channel, the left word of a frame leaves before the right word of that frame.
- R7: Channels with different bit-clock rates can run at the same time. Every word of every channel reaches the output in that channel's order, and no word reaches it twice. The queue accepts at most one word per system clock.
- R8: The shared queue holds 8 words and each channel buffer holds 2. While `out_valid` is 1 and `out_ready` is 0, `out_data` and its tags stay unchanged.
- R9: If a channel finishes a word while both the queue and its own buffer are full, that word is discarded and `ovf_flag` for that channel is set. The flag stays set until reset. The flags of the other channels are not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it oversamples all serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | NUM_CH | Bit clock of each channel |
| fs_in | input | NUM_CH | Frame-select line of each channel |
| sd_in | input | NUM_CH | Serial data line of each channel |
| cfg_fmt | input | 2*NUM_CH | Format code per channel (0 I2S, 1 left-justified, 2 right-justified) |
| cfg_wsel | input | 3*NUM_CH | Width code per channel |
| out_valid | output | 1 | The queue holds a word |
| out_ready | input | 1 | The consumer takes the word at this edge |
| out_data | output | 32 | Sample, MSB-aligned |
| out_ch | output | CH_W | Channel index of the word |
| out_right | output | 1 | 1 for a right sample |
| ovf_flag | output | NUM_CH | Sticky per-channel discard flags |

## Verification
The bench builds the block with its default parameters: eight channels, an eight-word queue, two-word channel buffers and two synchronizer stages. With eight channels, every format and width code can be assigned to a channel of its own. This lets all of them run at the same time at three different bit-clock rates. The small queue and buffer sizes make overflow reachable: a single right-justified channel, with the reader stalled, loses its eleventh word after only six frames. That same stall checks both the discard rule and the hold rule.

// File: rtl/aim_pkg.sv
package aim_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    FMT_I2S = 2'd0,
    FMT_LJ  = 2'd1,
    FMT_RJ  = 2'd2,
    FMT_RSV = 2'd3
  } fmt_e;

  typedef struct packed {
    logic              right;
    logic [WORD_W-1:0] data;
  } half_word_t;

  // width code -> number of sample bits
  function automatic logic [5:0] word_bits(input logic [2:0] wsel);
    case (wsel)
      3'd0:    return 6'd16;
      3'd1:    return 6'd18;
      3'd2:    return 6'd20;
      3'd3:    return 6'd24;
      default: return 6'd32;
    endcase
  endfunction

  // keep the low w bits of raw and move them up to the MSB end
  function automatic logic [WORD_W-1:0] left_align(input logic [WORD_W-1:0] raw,
                                                   input logic [5:0] w);
    logic [WORD_W-1:0] m;
    m = (w == 6'd32) ? '1 : ((32'd1 << w) - 32'd1);
    return (raw & m) << (6'd32 - w);
  endfunction

endpackage

// File: rtl/aim_lane.sv
module aim_lane
  import aim_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BUF_DEPTH   = 2,
  localparam int BW = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1,
  localparam int OW = $clog2(BUF_DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_i,
  input  logic       fs_i,
  input  logic       sd_i,
  input  logic [1:0] fmt_i,
  input  logic [2:0] wsel_i,
  input  logic       pop_i,
  output logic       req_o,
  output half_word_t word_o,
  output logic       ovf_o
);

  // input synchronizers
  logic [SYNC_STAGES-1:0] sclk_sy, fs_sy, sd_sy;
  logic sclk_last;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sy <= '0; fs_sy <= '0; sd_sy <= '0; sclk_last <= 1'b0;
    end else begin
      sclk_sy   <= {sclk_sy[SYNC_STAGES-2:0], sclk_i};
      fs_sy     <= {fs_sy[SYNC_STAGES-2:0], fs_i};
      sd_sy     <= {sd_sy[SYNC_STAGES-2:0], sd_i};
      sclk_last <= sclk_sy[SYNC_STAGES-1];
    end
  end

  logic sclk_s, fs_s, sd_s, bit_tick;
  assign sclk_s   = sclk_sy[SYNC_STAGES-1];
  assign fs_s     = fs_sy[SYNC_STAGES-1];
  assign sd_s     = sd_sy[SYNC_STAGES-1];
  assign bit_tick = sclk_s & ~sclk_last;

  // deserializer state, advanced once per bit
  logic             fs_d_q, fs_dd_q, locked_q;
  logic [5:0]       cnt_q, cnt_nx, wlen;
  logic [WORD_W-1:0] sh_q, sh_nx;
  logic             is_i2s, is_rj, cur_fs, prv_fs, fs_edge;
  logic             word_push;
  half_word_t       word_new;

  always_comb begin
    is_i2s  = (fmt_i == FMT_I2S);
    is_rj   = (fmt_i == FMT_RJ);
    wlen    = word_bits(wsel_i);
    // I2S looks at frame-select one bit late, which turns it into left-justified
    cur_fs  = is_i2s ? fs_d_q  : fs_s;
    prv_fs  = is_i2s ? fs_dd_q : fs_d_q;
    fs_edge = cur_fs ^ prv_fs;
    cnt_nx  = fs_edge ? 6'd0 : ((cnt_q == 6'd63) ? cnt_q : cnt_q + 6'd1);
    sh_nx   = {sh_q[WORD_W-2:0], sd_s};
    word_push = 1'b0;
    word_new  = '0;
    if (bit_tick) begin
      if (is_rj) begin
        if (fs_edge && locked_q && (cnt_q >= wlen - 6'd1)) begin
          word_push      = 1'b1;
          word_new.data  = left_align(sh_q, wlen);
          word_new.right = ~prv_fs;
        end
      end else if ((locked_q | fs_edge) && (cnt_nx == wlen - 6'd1)) begin
        word_push      = 1'b1;
        word_new.data  = left_align(sh_nx, wlen);
        word_new.right = is_i2s ? cur_fs : ~cur_fs;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_d_q <= 1'b0; fs_dd_q <= 1'b0; locked_q <= 1'b0;
      cnt_q  <= '0;   sh_q    <= '0;
    end else if (bit_tick) begin
      fs_d_q   <= fs_s;
      fs_dd_q  <= fs_d_q;
      locked_q <= locked_q | fs_edge;
      cnt_q    <= cnt_nx;
      sh_q     <= sh_nx;
    end
  end

  // local word buffer
  half_word_t      lbuf [BUF_DEPTH];
  logic [BW-1:0]   wr_idx, rd_idx;
  logic [OW-1:0]   occ_q;
  logic            push_ok, word_drop, ovf_q;

  function automatic logic [BW-1:0] bump(input logic [BW-1:0] p);
    return (p == BW'(BUF_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign push_ok   = word_push & ((occ_q != OW'(BUF_DEPTH)) | pop_i);
  assign word_drop = word_push & ~push_ok;
  assign req_o     = (occ_q != '0);
  assign word_o    = lbuf[rd_idx];
  assign ovf_o     = ovf_q;

  always_ff @(posedge clk) begin
    if (push_ok) lbuf[wr_idx] <= word_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx <= '0; rd_idx <= '0; occ_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (push_ok) wr_idx <= bump(wr_idx);
      if (pop_i)   rd_idx <= bump(rd_idx);
      occ_q <= occ_q + OW'(push_ok) - OW'(pop_i);
      if (word_drop) ovf_q <= 1'b1;
    end
  end

  a_r8_lane_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ_q <= OW'(BUF_DEPTH));
  a_r7_pop_needs_word: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> req_o);
  a_r9_flag_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_o) |-> $past(word_push));

endmodule

// File: rtl/aim_rr_arb.sv
module aim_rr_arb #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  input  logic          en_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] win_o
);

  logic [IW-1:0] ptr_q;
  logic          found;

  function automatic logic [IW-1:0] wrap_idx(input logic [IW-1:0] base, input int k);
    int s;
    s = int'(base) + k;
    if (s >= N) s = s - N;
    return s[IW-1:0];
  endfunction

  always_comb begin
    gnt_o = '0;
    win_o = ptr_q;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (!found && en_i && req_i[wrap_idx(ptr_q, k)]) begin
        found = 1'b1;
        win_o = wrap_idx(ptr_q, k);
        gnt_o[wrap_idx(ptr_q, k)] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (found) ptr_q <= (win_o == IW'(N - 1)) ? '0 : win_o + 1'b1;
  end

  a_r7_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));
  a_r7_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (gnt_o == '0));

endmodule

// File: rtl/aim_fifo.sv
module aim_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         full,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data
);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt_q;
  logic          rd_fire;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt_q == CW'(DEPTH));
  assign rd_valid = (cnt_q != '0);
  assign rd_data  = mem[rd_ptr];
  assign rd_fire  = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt_q <= '0;
    end else begin
      if (wr_en)   wr_ptr <= step(wr_ptr);
      if (rd_fire) rd_ptr <= step(rd_ptr);
      cnt_q <= cnt_q + CW'(wr_en) - CW'(rd_fire);
    end
  end

  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !full);
  a_r8_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/audio_in_mux.sv
module audio_in_mux
  import aim_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int FIFO_DEPTH  = 8,
  parameter int LANE_BUF    = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   sclk_in,
  input  logic [NUM_CH-1:0]   fs_in,
  input  logic [NUM_CH-1:0]   sd_in,
  input  logic [2*NUM_CH-1:0] cfg_fmt,
  input  logic [3*NUM_CH-1:0] cfg_wsel,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WORD_W-1:0]   out_data,
  output logic [CH_W-1:0]     out_ch,
  output logic                out_right,
  output logic [NUM_CH-1:0]   ovf_flag
);

  localparam int ENTRY_W = CH_W + 1 + WORD_W;

  half_word_t          lane_word [NUM_CH];
  logic [NUM_CH-1:0]   lane_req, lane_gnt;
  logic [CH_W-1:0]     win;
  logic                q_full, q_write;
  logic [ENTRY_W-1:0]  q_in, q_out;
  half_word_t          sel_word;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    aim_lane #(
      .SYNC_STAGES(SYNC_STAGES),
      .BUF_DEPTH  (LANE_BUF)
    ) u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .sclk_i(sclk_in[c]),
      .fs_i  (fs_in[c]),
      .sd_i  (sd_in[c]),
      .fmt_i (cfg_fmt[2*c +: 2]),
      .wsel_i(cfg_wsel[3*c +: 3]),
      .pop_i (lane_gnt[c]),
      .req_o (lane_req[c]),
      .word_o(lane_word[c]),
      .ovf_o (ovf_flag[c])
    );
  end

  aim_rr_arb #(.N(NUM_CH)) u_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req_i(lane_req),
    .en_i (~q_full),
    .gnt_o(lane_gnt),
    .win_o(win)
  );

  assign q_write  = |lane_gnt;
  assign sel_word = lane_word[win];
  assign q_in     = {win, sel_word.right, sel_word.data};

  aim_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (q_write),
    .wr_data (q_in),
    .full    (q_full),
    .rd_valid(out_valid),
    .rd_ready(out_ready),
    .rd_data (q_out)
  );

  assign out_ch    = q_out[ENTRY_W-1 -: CH_W];
  assign out_right = q_out[WORD_W];
  assign out_data  = q_out[WORD_W-1:0];

  // R6: the tag leaving the queue names a channel that exists
  a_r6_channel_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_ch) < NUM_CH));

endmodule

// File: tb/audio_in_mux_test.sv
`timescale 1ns/1ps
module audio_in_mux_test;

  localparam int NCH = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n;
  logic [NCH-1:0]   sclk_v, fs_v, sd_v, ovf;
  logic [2*NCH-1:0] fmt_v;
  logic [3*NCH-1:0] wsel_v;
  logic             out_valid, out_ready, out_right;
  logic [31:0]      out_data;
  logic [2:0]       out_ch;

  int n_chk = 0;
  int n_fail = 0;
  logic [35:0] exp_q[$];   // {ch, right, data}

  audio_in_mux uut (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_v), .fs_in(fs_v), .sd_in(sd_v),
    .cfg_fmt(fmt_v), .cfg_wsel(wsel_v), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_ch(out_ch), .out_right(out_right), .ovf_flag(ovf)
  );

  // channel plan: 0,1 I2S; 2,3 left-justified; 4..7 right-justified
  function automatic int fmt_of(input int ch);
    return (ch < 2) ? 0 : (ch < 4) ? 1 : 2;
  endfunction
  function automatic int wcode_of(input int ch);
    case (ch)
      0, 2, 7: return 3;
      1, 3:    return 4;
      4:       return 0;
      5:       return 1;
      default: return 2;
    endcase
  endfunction
  function automatic int width_of(input int ch);
    int t[5] = '{16, 18, 20, 24, 32};
    return t[wcode_of(ch)];
  endfunction
  function automatic string req_of(input int ch);
    return (fmt_of(ch) == 0) ? "R3" : (fmt_of(ch) == 1) ? "R2" : "R4";
  endfunction
  // expected word: only the top w bits carry the sample (R5)
  function automatic logic [31:0] gen_word(input int ch, input int n, input int w);
    logic [31:0] raw;
    raw = (32'h9E37_79B1 * (32'(n) * 32'd8 + 32'(ch) + 32'd1)) ^ 32'hA5C3_0F96;
    return raw & (32'hFFFF_FFFF << (32 - w));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // lead pad, nfr frames, tail pad; the first `keep` words are expected
  task automatic send_frames(input int ch, input int nfr, input int hp,
                             input int keep, input int base);
    int fm, w, total;
    bit lv, prev, lj, fsb, sdb;
    logic [31:0] cur;
    fm = fmt_of(ch); w = width_of(ch);
    lv = (fm == 0) ? 1'b0 : 1'b1;
    prev = 1'b0; cur = '0;
    total = nfr * 64 + 4;
    for (int p = 0; p < total; p++) begin
      if (p < 2) begin
        fsb = !lv; lj = 1'b0;
      end else if (p >= nfr * 64 + 2) begin
        fsb = lv; lj = 1'b0;
      end else begin
        int q, f, h, k;
        q = p - 2; f = q / 64; h = (q % 64) / 32; k = q % 32;
        if (k == 0) begin
          cur = gen_word(ch, base + f * 2 + h, w);
          if (f * 2 + h < keep) exp_q.push_back({3'(ch), h[0], cur});
        end
        fsb = (h == 0) ? lv : !lv;
        // unused slot bits are driven high: they must not reach the output (R5)
        if (fm == 2) lj = (k < 32 - w) ? 1'b1 : cur[31 - (k - (32 - w))];
        else         lj = (k < w) ? cur[31 - k] : 1'b1;
      end
      sdb  = (fm == 0) ? prev : lj;
      prev = lj;
      @(negedge clk);
      fs_v[ch] = fsb; sd_v[ch] = sdb;
      repeat (hp) @(negedge clk);
      sclk_v[ch] = 1'b1;
      repeat (hp) @(negedge clk);
      sclk_v[ch] = 1'b0;
    end
  endtask

  task automatic wait_drain(input string req);
    int t;
    t = 0;
    while (exp_q.size() != 0 && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (40) @(negedge clk);
    check(exp_q.size() == 0, req, "words still missing", 64'(exp_q.size()), 64'd0);
    check(out_valid == 1'b0, req, "extra word left in queue", 64'(out_valid), 64'd0);
  endtask

  // scoreboard monitor: pops the oldest expected word of the same channel
  initial begin
    int idx;
    forever begin
      @(negedge clk); #1;
      if (rst_n === 1'b1 && out_valid && out_ready) begin
        idx = -1;
        for (int i = 0; i < exp_q.size(); i++)
          if (exp_q[i][35:33] == out_ch) begin idx = i; break; end
        n_chk++;
        if (idx < 0) begin
          n_fail++;
          $display("FAIL R7: unexpected word ch=%0d actual=%h expected=none", out_ch, out_data);
        end else begin
          // R5 alignment, R6 side tag and order
          if (exp_q[idx][32:0] != {out_right, out_data}) begin
            n_fail++;
            $display("FAIL %s/R6: ch=%0d actual right=%0d data=%h expected right=%0d data=%h",
                     req_of(int'(out_ch)), out_ch, out_right, out_data,
                     exp_q[idx][32], exp_q[idx][31:0]);
          end
          exp_q.delete(idx);
        end
      end
    end
  end

  initial begin
    logic [31:0] held;
    rst_n = 1'b0; out_ready = 1'b1;
    sclk_v = '0; fs_v = '0; sd_v = '0;
    for (int c = 0; c < NCH; c++) begin
      fmt_v[2*c +: 2]  = 2'(fmt_of(c));
      wsel_v[3*c +: 3] = 3'(wcode_of(c));
    end
    fork
      begin
        repeat (5) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'd0);
        check(ovf == '0, "R1", "ovf_flag in reset", 64'(ovf), 64'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // one channel at a time: R2, R3, R4, R5, R6
        for (int c = 0; c < NCH; c++) begin
          send_frames(c, 2, 3, 4, c * 16);
          wait_drain(req_of(c));
        end
        check(ovf == '0, "R9", "no flag without overflow", 64'(ovf), 64'd0);

        // all channels at once, three bit-clock rates: R7
        for (int c = 0; c < NCH; c++) begin
          automatic int cc = c;
          fork
            send_frames(cc, 3, 2 + cc % 3, 6, 200 + cc * 16);
          join_none
        end
        wait fork;
        wait_drain("R7");
        check(ovf == '0, "R9", "no flag after concurrent run", 64'(ovf), 64'd0);

        // reader stalled: 8 in queue + 2 in buffer kept, 4 dropped (R8, R9)
        out_ready = 1'b0;
        send_frames(7, 7, 3, 10, 400);
        repeat (50) @(negedge clk);
        check(ovf == 8'h80, "R9", "flag only on channel 7", 64'(ovf), 64'h80);
        check(out_valid == 1'b1, "R8", "valid while stalled", 64'(out_valid), 64'd1);
        held = out_data;
        repeat (30) @(negedge clk);
        check(out_data == held, "R8", "data held while stalled", 64'(out_data), 64'(held));
        check(out_data == gen_word(7, 400, 24), "R8", "oldest word at head",
              64'(out_data), 64'(gen_word(7, 400, 24)));
        out_ready = 1'b1;
        wait_drain("R8");
        check(ovf == 8'h80, "R9", "flag stays set", 64'(ovf), 64'h80);
      end
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R7: watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule